// File: doc/BRIEF.md
# TMDS Three-Channel Link Encoder and Serializer

This block turns a stream of pixels into three serial bit lanes for a DVI-style link. Each lane carries one colour: blue, green or red. A pixel carries three colour bytes, a horizontal and a vertical sync bit, and an active-video flag. Pixels enter through a valid/ready handshake with room for exactly one pixel. Once per character slot the held pixel is turned into three 10-bit characters, one per lane. During active video a lane sends its colour byte, recoded to cut transitions and keep the line DC balanced. During blanking a lane sends one of four control tokens instead.

Only the blue lane carries sync in its control bits, and each sync can be suppressed by an enable pin. The green and red control bits are always zero. One clock runs at the bit rate, or faster with a qualifying enable. Each enabled clock shifts one bit out of every lane, least significant bit first. Ten enabled clocks make one character slot. An output-mode code of all ones powers the lanes down, which holds every serial output low. The handshake keeps working in that mode.

Top module: `tmds_link_tx`

## Requirements
- R1: `pix_ready` is high exactly when no pixel is held. A transfer happens on a clock edge where `pix_valid` and `pix_ready` are both high. A held pixel is consumed by the next character load, so `pix_ready` stays low until that load. While `pix_ready` is low the source must keep the pixel stable.
- R2: For a pixel with `pix_de` low, each lane sends a control token chosen by its control bits {c1,c0}: 00 gives 10'h354, 01 gives 10'h0AB, 10 gives 10'h154 and 11 gives 10'h2AB. Sending a token resets that lane's running disparity to zero.
- R3: On the blue lane, c0 is `pix_hsync & hsync_en` and c1 is `pix_vsync & vsync_en`. On the green and red lanes, c0 and c1 are always 0.
- R4: For a pixel with `pix_de` high, bits 7:0 of the character come from the colour byte chained with XNOR or XOR. XNOR is used when the byte has more than four ones, or exactly four ones with bit 0 clear; otherwise XOR is used. Bit 8 is 1 for XOR and 0 for XNOR. Bit 9 set means bits 7:0 were inverted. Decoding with these rules returns the original byte.
- R5: The choice of inversion drives the ones-minus-zeros count of the lane since its last control token toward zero. That count never leaves the range -10 to +10.
- R6: Each character is sent least significant bit first, one bit per enabled clock. A new character is loaded on the enabled clock that follows the tenth bit. The first enabled clock after reset loads a character.
- R7: On a clock where `bit_en` is low, no lane changes its serial output and no character is loaded.
- R8: When `out_mode` is 4'hF, all three serial outputs are held at 0. Any other value gives normal output. The handshake and character timing continue in either case.
- R9: After reset, `pix_ready` is 1, all serial outputs are 0 and every running disparity is 0.
- R10: If no pixel is held at a character load, every lane sends the token for control value 00 (10'h354), whatever the sync inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Qualifies a clock as one serial bit time |
| pix_valid | input | 1 | Source offers a pixel |
| pix_ready | output | 1 | Pixel holding slot is empty |
| pix_de | input | 1 | 1 for active video, 0 for blanking |
| pix_hsync | input | 1 | Horizontal sync for the blue lane |
| pix_vsync | input | 1 | Vertical sync for the blue lane |
| pix_blue | input | 8 | Blue colour byte |
| pix_green | input | 8 | Green colour byte |
| pix_red | input | 8 | Red colour byte |
| hsync_en | input | 1 | Pass horizontal sync (0 sends it as 0) |
| vsync_en | input | 1 | Pass vertical sync (0 sends it as 0) |
| out_mode | input | 4 | Output mode; 4'hF powers the lanes down |
| tx_blue | output | 1 | Serial lane 0 (blue) |
| tx_green | output | 1 | Serial lane 1 (green) |
| tx_red | output | 1 | Serial lane 2 (red) |

## Verification
The hardest states to reach from the ports are character slots stretched by a sparse `bit_en`, and a pixel held under back-pressure with the bit timer stopped. The bench drives `bit_en` in three modes: every clock, one clock in three, and never. It pushes pixels through the handshake in each mode. The serial stream is rebuilt by counting enabled clocks from reset and framing every ten bits into a character. Each burst starts with an all-zero active pixel whose character is 10'h100. That marker lets the bench align every lane past the idle tokens. The bench then checks each character against its own encoder model, decodes it back to the byte or control value, and tracks the running disparity.

// File: rtl/tmds_pkg.sv
package tmds_pkg;
  localparam int SYM_W  = 10;
  localparam int BYTE_W = 8;
  localparam int DISP_W = 6;
  localparam int NCH    = 3;

  typedef logic [SYM_W-1:0]         sym_t;
  typedef logic signed [DISP_W-1:0] disp_t;

  typedef struct packed {
    logic              de;
    logic [1:0]        ctl;
    logic [BYTE_W-1:0] dat;
  } chan_in_t;

  typedef struct packed {
    logic              de;
    logic              hs;
    logic              vs;
    logic [BYTE_W-1:0] b;
    logic [BYTE_W-1:0] g;
    logic [BYTE_W-1:0] r;
  } pix_t;

  function automatic sym_t ctl_token(input logic [1:0] c);
    case (c)
      2'b00:   return 10'h354;
      2'b01:   return 10'h0AB;
      2'b10:   return 10'h154;
      default: return 10'h2AB;
    endcase
  endfunction
endpackage

// File: rtl/tmds_bit_timer.sv
module tmds_bit_timer #(
  parameter int SYM_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  output logic load
);
  localparam int CW = $clog2(SYM_W);
  localparam logic [CW-1:0] LAST = CW'(SYM_W - 1);

  logic [CW-1:0] pos_q;

  assign load = bit_en && (pos_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= LAST;
    else if (load)   pos_q <= '0;
    else if (bit_en) pos_q <= pos_q + 1'b1;
  end

  // R6: two loads are always at least one full character apart
  a_r6_load_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
endmodule

// File: rtl/tmds_chan_enc.sv
module tmds_chan_enc
  import tmds_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  chan_in_t in,
  output sym_t     sym
);
  disp_t disp_q;
  disp_t disp_d;

  always_comb begin
    logic [8:0] qm;
    int n1, q1, q0, acc;
    logic use_xnor;

    n1 = 0;
    for (int i = 0; i < BYTE_W; i++) n1 += int'(in.dat[i]);
    use_xnor = (n1 > 4) || (n1 == 4 && !in.dat[0]);

    qm[0] = in.dat[0];
    for (int i = 1; i < BYTE_W; i++)
      qm[i] = use_xnor ? ~(qm[i-1] ^ in.dat[i]) : (qm[i-1] ^ in.dat[i]);
    qm[8] = ~use_xnor;

    q1 = 0;
    for (int i = 0; i < BYTE_W; i++) q1 += int'(qm[i]);
    q0  = BYTE_W - q1;
    acc = int'(disp_q);

    if (!in.de) begin
      sym = ctl_token(in.ctl);
      acc = 0;
    end else if (acc == 0 || q1 == q0) begin
      sym = {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
      acc = qm[8] ? acc + q1 - q0 : acc + q0 - q1;
    end else if ((acc > 0 && q1 > q0) || (acc < 0 && q0 > q1)) begin
      sym = {1'b1, qm[8], ~qm[7:0]};
      acc = acc + (qm[8] ? 2 : 0) + q0 - q1;
    end else begin
      sym = {1'b0, qm[8], qm[7:0]};
      acc = acc - (qm[8] ? 0 : 2) + q1 - q0;
    end
    disp_d = disp_t'(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    disp_q <= '0;
    else if (load) disp_q <= disp_d;
  end

  // R5: running disparity stays inside +/-10
  a_r5_disp_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_q >= -10) && (disp_q <= 10));
  // R2: a token sent clears the disparity
  a_r2_token_clears_disp: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !in.de) |=> (disp_q == '0));
  // R4: sparse bytes take the XOR chain, marked by bit 8
  a_r4_xor_marked: assert property (@(posedge clk) disable iff (!rst_n)
    (in.de && $countones(in.dat) < 4) |-> sym[8]);
endmodule

// File: rtl/tmds_chan_ser.sv
module tmds_chan_ser
  import tmds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic load,
  input  sym_t sym,
  output logic sdo
);
  sym_t sreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sreg_q <= '0;
    else if (load)   sreg_q <= sym;
    else if (bit_en) sreg_q <= {1'b0, sreg_q[SYM_W-1:1]};
  end

  assign sdo = sreg_q[0];

  // R6: a load captures the whole character
  a_r6_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sreg_q == $past(sym)));
  // R6: each enabled clock moves the next higher bit to the output
  a_r6_lsb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !load) |=> (sreg_q[SYM_W-2:0] == $past(sreg_q[SYM_W-1:1])));
  // R7: nothing moves without the bit enable
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sreg_q));
endmodule

// File: rtl/tmds_link_tx.sv
module tmds_link_tx
  import tmds_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       pix_valid,
  output logic       pix_ready,
  input  logic       pix_de,
  input  logic       pix_hsync,
  input  logic       pix_vsync,
  input  logic [7:0] pix_blue,
  input  logic [7:0] pix_green,
  input  logic [7:0] pix_red,
  input  logic       hsync_en,
  input  logic       vsync_en,
  input  logic [3:0] out_mode,
  output logic       tx_blue,
  output logic       tx_green,
  output logic       tx_red
);
  localparam logic [3:0] MODE_OFF = 4'hF;

  logic     load;
  logic     full_q;
  pix_t     hold_q;
  chan_in_t ch_in [NCH];
  logic [NCH-1:0] sdo;
  logic     accept;
  logic     pwr_down;

  assign pix_ready = !full_q;
  assign accept    = pix_valid && pix_ready;
  assign pwr_down  = (out_mode == MODE_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      hold_q <= '{de: pix_de, hs: pix_hsync, vs: pix_vsync,
                  b: pix_blue, g: pix_green, r: pix_red};
    end else if (load) begin
      full_q <= 1'b0;
    end
  end

  always_comb begin
    logic live_de;
    live_de  = full_q && hold_q.de;
    ch_in[0] = '{de: live_de, dat: hold_q.b,
                 ctl: full_q ? {hold_q.vs & vsync_en, hold_q.hs & hsync_en} : 2'b00};
    ch_in[1] = '{de: live_de, dat: hold_q.g, ctl: 2'b00};
    ch_in[2] = '{de: live_de, dat: hold_q.r, ctl: 2'b00};
  end

  tmds_bit_timer #(.SYM_W(SYM_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    sym_t lane_sym;
    tmds_chan_enc u_enc (
      .clk(clk), .rst_n(rst_n), .load(load), .in(ch_in[c]), .sym(lane_sym)
    );
    tmds_chan_ser u_ser (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(load),
      .sym(lane_sym), .sdo(sdo[c])
    );
  end

  assign tx_blue  = sdo[0] & ~pwr_down;
  assign tx_green = sdo[1] & ~pwr_down;
  assign tx_red   = sdo[2] & ~pwr_down;

  // R1: a held pixel leaves at a load and frees the slot
  a_r1_slot_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (load && full_q) |=> pix_ready);
  // R1: a held pixel is not replaced before it is sent
  a_r1_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !load) |=> (full_q && $stable(hold_q)));
  // R8: lanes stay quiet in power down
  a_r8_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !(tx_blue || tx_green || tx_red));
endmodule

// File: tb/tmds_link_tx_bench.sv
`timescale 1ns/1ps
module tmds_link_tx_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic bit_en = 0;
  logic pix_valid = 0;
  logic pix_ready;
  logic pix_de = 0, pix_hsync = 0, pix_vsync = 0;
  logic [7:0] pix_blue = 0, pix_green = 0, pix_red = 0;
  logic hsync_en = 1, vsync_en = 1;
  logic [3:0] out_mode = 0;
  logic tx_blue, tx_green, tx_red;

  int n_chk = 0, n_fail = 0;
  int en_mode = 2;
  int en_cnt = 0;

  always #2 clk = ~clk;

  tmds_link_tx u_tmds_link_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_de(pix_de), .pix_hsync(pix_hsync),
    .pix_vsync(pix_vsync), .pix_blue(pix_blue), .pix_green(pix_green),
    .pix_red(pix_red), .hsync_en(hsync_en), .vsync_en(vsync_en),
    .out_mode(out_mode), .tx_blue(tx_blue), .tx_green(tx_green), .tx_red(tx_red)
  );

  always @(negedge clk) begin
    en_cnt <= en_cnt + 1;
    case (en_mode)
      0:       bit_en <= 1'b1;
      1:       bit_en <= (en_cnt % 3 == 0);
      default: bit_en <= 1'b0;
    endcase
  end

  // stream monitor: frames every ten enabled bits into a character
  logic en_seen = 0;
  int bitpos = 0;
  int stab_err = 0;
  logic [9:0] acc_b, acc_g, acc_r;
  logic [2:0] last_tx = 0;
  logic [9:0] q_b[$], q_g[$], q_r[$];

  always @(posedge clk) en_seen <= bit_en;

  always @(negedge clk) begin
    if (!rst_n) begin
      bitpos = 0;
    end else if (en_seen) begin
      acc_b[bitpos] = tx_blue; acc_g[bitpos] = tx_green; acc_r[bitpos] = tx_red;
      if (bitpos == 9) begin
        q_b.push_back(acc_b); q_g.push_back(acc_g); q_r.push_back(acc_r);
        bitpos = 0;
      end else bitpos++;
    end else if ({tx_red, tx_green, tx_blue} != last_tx) begin
      stab_err++;
    end
    last_tx = {tx_red, tx_green, tx_blue};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] get_sym(input int c, input int i);
    if (c == 0) return q_b[i];
    if (c == 1) return q_g[i];
    return q_r[i];
  endfunction

  function automatic int qlen();
    return q_r.size();
  endfunction

  // independent model of the encoding rules
  function automatic logic [9:0] ref_sym(input logic de, input logic [1:0] c,
                                         input logic [7:0] d, input int din, output int dout);
    logic [8:0] qm;
    int n1, a, b;
    logic xn;
    if (!de) begin
      dout = 0;
      case (c)
        2'b00: return 10'h354;
        2'b01: return 10'h0AB;
        2'b10: return 10'h154;
        default: return 10'h2AB;
      endcase
    end
    n1 = $countones(d);
    xn = (n1 > 4) || (n1 == 4 && d[0] == 1'b0);
    qm[0] = d[0];
    for (int i = 1; i < 8; i++) qm[i] = xn ? ~(qm[i-1] ^ d[i]) : (qm[i-1] ^ d[i]);
    qm[8] = !xn;
    a = $countones(qm[7:0]); b = 8 - a;
    if (din == 0 || a == b) begin
      dout = qm[8] ? din + a - b : din + b - a;
      return {~qm[8], qm[8], qm[8] ? qm[7:0] : ~qm[7:0]};
    end
    if ((din > 0 && a > b) || (din < 0 && b > a)) begin
      dout = din + (qm[8] ? 2 : 0) + b - a;
      return {1'b1, qm[8], ~qm[7:0]};
    end
    dout = din - (qm[8] ? 0 : 2) + a - b;
    return {1'b0, qm[8], qm[7:0]};
  endfunction

  function automatic logic [7:0] dec_byte(input logic [9:0] s);
    logic [7:0] q, d;
    q = s[9] ? ~s[7:0] : s[7:0];
    d[0] = q[0];
    for (int i = 1; i < 8; i++) d[i] = s[8] ? (q[i] ^ q[i-1]) : ~(q[i] ^ q[i-1]);
    return d;
  endfunction

  function automatic int dec_ctl(input logic [9:0] s);
    case (s)
      10'h354: return 0;
      10'h0AB: return 1;
      10'h154: return 2;
      10'h2AB: return 3;
      default: return -1;
    endcase
  endfunction

  // burst description (marker pixel is prepended by run_burst)
  int n_px;
  logic px_de[16], px_hs[16], px_vs[16];
  logic [7:0] px_b[16], px_g[16], px_r[16];

  task automatic push(input logic de, input logic hs, input logic vs,
                      input logic [7:0] b, input logic [7:0] g, input logic [7:0] r);
    @(negedge clk);
    pix_valid = 1; pix_de = de; pix_hsync = hs; pix_vsync = vs;
    pix_blue = b; pix_green = g; pix_red = r;
    while (!pix_ready) @(negedge clk);
    @(negedge clk);
    pix_valid = 0;
  endtask

  task automatic run_burst(input string tag, input int slot_clks);
    int start, base, dref, dnext, sum, worst, ones;
    logic [9:0] got, exp;
    logic [1:0] c;
    start = qlen();
    push(1, 0, 0, 8'h00, 8'h00, 8'h00);
    for (int i = 0; i < n_px; i++)
      push(px_de[i], px_hs[i], px_vs[i], px_b[i], px_g[i], px_r[i]);
    repeat ((n_px + 4) * slot_clks) @(negedge clk);
    for (int ch = 0; ch < 3; ch++) begin
      base = -1;
      for (int i = start; i < qlen(); i++)
        if (get_sym(ch, i) != 10'h354) begin base = i; break; end
      chk(base >= 0 && get_sym(ch, base) == 10'h100, {tag, " R6 marker"},
          base < 0 ? 0 : int'(get_sym(ch, base)), 10'h100);
      if (base < 0 || base + n_px >= qlen()) continue;
      dref = -8; sum = -8; worst = 8;
      for (int i = 0; i < n_px; i++) begin
        c = (ch == 0) ? {px_vs[i] & vsync_en, px_hs[i] & hsync_en} : 2'b00;
        exp = ref_sym(px_de[i], c,
                      ch == 0 ? px_b[i] : (ch == 1 ? px_g[i] : px_r[i]), dref, dnext);
        dref = dnext;
        got = get_sym(ch, base + 1 + i);
        chk(got == exp, px_de[i] ? {tag, " R4 R6 character"} : {tag, " R2 R3 token"},
            int'(got), int'(exp));
        if (px_de[i]) begin
          chk(dec_byte(got) == (ch == 0 ? px_b[i] : (ch == 1 ? px_g[i] : px_r[i])),
              {tag, " R4 decode"}, int'(dec_byte(got)),
              int'(ch == 0 ? px_b[i] : (ch == 1 ? px_g[i] : px_r[i])));
          ones = $countones(got);
          sum = sum + 2 * ones - 10;
          if (sum > worst) worst = sum;
          if (-sum > worst) worst = -sum;
        end else begin
          chk(dec_ctl(got) == int'(c), {tag, " R2 control decode"}, dec_ctl(got), int'(c));
          sum = 0;
        end
      end
      chk(worst <= 10, {tag, " R5 disparity bound"}, worst, 10);
    end
  endtask

  task automatic set_px(input int i, input logic de, input logic hs, input logic vs,
                        input logic [7:0] b, input logic [7:0] g, input logic [7:0] r);
    px_de[i] = de; px_hs[i] = hs; px_vs[i] = vs; px_b[i] = b; px_g[i] = g; px_r[i] = r;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pix_ready == 1'b1, "R9 ready after reset", int'(pix_ready), 1);
    chk({tx_red, tx_green, tx_blue} == 3'b000, "R9 lanes low after reset",
        int'({tx_red, tx_green, tx_blue}), 0);
  endtask

  task automatic t_active();
    en_mode = 0;
    n_px = 12;
    set_px(0, 1, 0, 0, 8'hFF, 8'h00, 8'h55);
    set_px(1, 1, 0, 0, 8'hAA, 8'h0F, 8'hF0);
    set_px(2, 1, 0, 0, 8'h10, 8'h78, 8'h87);
    set_px(3, 1, 0, 0, 8'h1E, 8'hE1, 8'h3C);
    set_px(4, 1, 0, 0, 8'hFE, 8'h01, 8'h7F);
    set_px(5, 1, 0, 0, 8'h80, 8'hC3, 8'h5A);
    set_px(6, 1, 0, 0, 8'hFF, 8'hFF, 8'hFF);
    set_px(7, 1, 0, 0, 8'hFF, 8'hFF, 8'hFF);
    set_px(8, 1, 0, 0, 8'h00, 8'h00, 8'h00);
    set_px(9, 1, 0, 0, 8'h33, 8'hCC, 8'h96);
    set_px(10, 1, 0, 0, 8'h69, 8'h2D, 8'hD2);
    set_px(11, 1, 0, 0, 8'h08, 8'hF7, 8'h4B);
    run_burst("active", 10);
  endtask

  task automatic t_blanking();
    en_mode = 0;
    hsync_en = 1; vsync_en = 1;
    n_px = 6;
    set_px(0, 0, 0, 0, 8'h12, 8'h34, 8'h56);
    set_px(1, 0, 1, 0, 8'hFF, 8'hFF, 8'hFF);
    set_px(2, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    set_px(3, 0, 1, 1, 8'hA5, 8'h5A, 8'hC3);
    set_px(4, 1, 1, 1, 8'hF0, 8'h0F, 8'hE7);
    set_px(5, 1, 0, 0, 8'h7E, 8'h81, 8'h24);
    run_burst("blank", 10);
  endtask

  task automatic t_sync_gate();
    en_mode = 0;
    n_px = 3;
    set_px(0, 0, 1, 1, 8'h00, 8'h00, 8'h00);
    set_px(1, 0, 1, 0, 8'h00, 8'h00, 8'h00);
    set_px(2, 0, 0, 1, 8'h00, 8'h00, 8'h00);
    hsync_en = 0; vsync_en = 1;
    run_burst("R3 hsync gated", 10);
    hsync_en = 1; vsync_en = 0;
    run_burst("R3 vsync gated", 10);
    hsync_en = 1; vsync_en = 1;
  endtask

  task automatic t_sparse_en();
    int s0;
    en_mode = 1;
    stab_err = 0;
    n_px = 5;
    set_px(0, 1, 0, 0, 8'h9C, 8'h63, 8'hB1);
    set_px(1, 0, 1, 1, 8'h00, 8'h00, 8'h00);
    set_px(2, 1, 0, 0, 8'hEF, 8'h10, 8'h44);
    set_px(3, 1, 0, 0, 8'hFF, 8'h00, 8'hFF);
    set_px(4, 1, 0, 0, 8'h3F, 8'hC0, 8'h77);
    run_burst("sparse R7", 30);
    chk(stab_err == 0, "R7 outputs steady without bit_en", stab_err, 0);
    en_mode = 0;
    repeat (30) @(negedge clk);
    s0 = qlen();
    chk(s0 > 0, "R6 characters framed", s0, 1);
  endtask

  task automatic t_backpressure();
    en_mode = 2;
    repeat (4) @(negedge clk);
    chk(pix_ready == 1'b1, "R1 ready while empty", int'(pix_ready), 1);
    push(1, 0, 0, 8'h11, 8'h22, 8'h33);
    chk(pix_ready == 1'b0, "R1 ready low while held", int'(pix_ready), 0);
    pix_valid = 1; pix_blue = 8'h99;
    repeat (30) @(negedge clk);
    chk(pix_ready == 1'b0, "R1 ready stays low without a load", int'(pix_ready), 0);
    pix_valid = 0;
    en_mode = 0;
    repeat (14) @(negedge clk);
    chk(pix_ready == 1'b1, "R1 slot freed by load", int'(pix_ready), 1);
  endtask

  task automatic t_idle();
    int l;
    en_mode = 0;
    pix_valid = 0; pix_hsync = 1; pix_vsync = 1; pix_de = 1;
    repeat (60) @(negedge clk);
    l = qlen();
    for (int ch = 0; ch < 3; ch++)
      chk(get_sym(ch, l - 1) == 10'h354 && get_sym(ch, l - 2) == 10'h354,
          "R10 idle token on underrun", int'(get_sym(ch, l - 1)), 10'h354);
    pix_hsync = 0; pix_vsync = 0;
  endtask

  task automatic t_power_down();
    int hi;
    en_mode = 0;
    out_mode = 4'hF;
    hi = 0;
    fork
      begin
        push(1, 0, 0, 8'hFF, 8'h0F, 8'hAA);
        push(0, 1, 1, 8'h00, 8'h00, 8'h00);
      end
      begin
        repeat (60) begin
          @(negedge clk);
          if (tx_blue || tx_green || tx_red) hi++;
        end
      end
    join
    chk(hi == 0, "R8 lanes held low in power down", hi, 0);
    chk(pix_ready == 1'b1, "R8 handshake runs in power down", int'(pix_ready), 1);
    out_mode = 4'h0;
    repeat (40) @(negedge clk);
    out_mode = 4'h3;
    n_px = 3;
    set_px(0, 1, 0, 0, 8'hC7, 8'h38, 8'h5D);
    set_px(1, 0, 0, 0, 8'h00, 8'h00, 8'h00);
    set_px(2, 1, 0, 0, 8'h01, 8'hFE, 8'h80);
    run_burst("R8 other mode", 10);
    out_mode = 4'h0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_active();
    t_blanking();
    t_sync_gate();
    t_sparse_en();
    t_backpressure();
    t_idle();
    t_power_down();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule